// File: doc/BRIEF.md
# Interrupt Source Channel Register

This block holds the control and status word for one source of a vectored interrupt controller. Software reaches it through a plain register port: an address-decoded select, a write enable, 32-bit write data and 32-bit read data. A raw hardware interrupt line also comes in. The word stores four things: a priority level, a target selector, an enable bit and an input polarity bit. It also keeps a software-raised interrupt flag. From these and the raw line the block computes a pending status. It drives that status to a shared summary register, and it drives a qualified request, with priority and target, to the arbitration logic.

Every writable field has its own write-enable bit in the same write word, so software can change one field without a read-modify-write. The software flag is set and cleared through two separate strobe bits. An optional synchronizer on the raw input is chosen by parameter.

Top module: `irq_chan_reg`

## Requirements
- R1: After reset, priority, target, enable, polarity and the software flag are all 0. With the raw input low, the read data is all zeros and the request is low.
- R2: Read bit 31 always equals the `pending` output. Software cannot write bit 31.
- R3: `pending` is (raw input XOR polarity bit) OR the software flag. A polarity bit of 1 means the raw input is active low.
- R4: A write with bit 30 = 1 sets the software flag. A write with bit 30 = 0 leaves the flag as it was.
- R5: A write with bit 29 = 1 clears the software flag. When bits 30 and 29 are both 1 in one write, the flag ends up cleared.
- R6: The priority field (bits 3:0) takes write bits 3:0 only when write bit 28 is 1. Otherwise it keeps its value.
- R7: The target field (bit 8) takes write bit 8 only when write bit 27 is 1 and the enable bit was 0 before that write. Otherwise it keeps its value.
- R8: The enable bit (bit 16) takes write bit 16 only when write bit 26 is 1.
- R9: The polarity bit (bit 17) takes write bit 17 only when write bit 25 is 1.
- R10: Read bits 30 down to 18 always read 0. This covers the strobe bits, the write-enable bits and the reserved bits 24:18. Bits 7:4, 15:9 also read 0. Bits 3:0, 8, 16 and 17 return the stored fields.
- R11: `req` is 1 exactly when pending is 1, enable is 1 and the priority is nonzero. `req_prio` and `req_tgt` always show the stored priority and target.
- R12: A write cycle with `sel` low or `wr_en` low changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register selected by address decode |
| wr_en | input | 1 | Write strobe, qualified by sel |
| wdata | input | 32 | Write data, including strobe and write-enable bits |
| rdata | output | 32 | Read data: stored fields and pending status |
| raw_irq | input | 1 | Raw hardware interrupt input |
| pending | output | 1 | Channel pending status, for the summary register |
| req | output | 1 | Qualified request to arbitration |
| req_prio | output | 4 | Stored priority level |
| req_tgt | output | 1 | Stored target selector |

## Verification
The hardest case to reach from the ports is a target write that lands while the channel is enabled. Here the target write-enable bit must have no effect, yet the same write word could also change other fields. The stimulus first enables the channel and tries a target change, which must be refused. It then clears enable in a separate write and repeats the target change, which must now take effect. Last, it issues a single all-ones write while the channel is still disabled, so the target change and the enable change race within one cycle. The set-and-clear collision on the software flag is reached the same way. The raw line is held at the level that leaves pending dependent on the flag alone, so the flag's state is visible on `pending` and on read bit 31.

// File: rtl/irq_chan_pkg.sv
package irq_chan_pkg;
   // bit positions in the register word
   localparam int unsigned BIT_PEND    = 31;
   localparam int unsigned BIT_SW_SET  = 30;
   localparam int unsigned BIT_SW_CLR  = 29;
   localparam int unsigned BIT_WE_PRIO = 28;
   localparam int unsigned BIT_WE_TGT  = 27;
   localparam int unsigned BIT_WE_EN   = 26;
   localparam int unsigned BIT_WE_POL  = 25;
   localparam int unsigned BIT_POL     = 17;
   localparam int unsigned BIT_EN      = 16;
   localparam int unsigned LSB_TGT     = 8;
   localparam int unsigned LSB_PRIO    = 0;
   localparam int unsigned DATA_W      = 32;

   // decoded strobes of one qualified write
   typedef struct packed {
      logic sw_set;
      logic sw_clr;
      logic we_prio;
      logic we_tgt;
      logic we_en;
      logic we_pol;
   } chan_strobe_t;
endpackage

// File: rtl/irq_chan_fields.sv
module irq_chan_fields
   import irq_chan_pkg::*;
#(
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned TGT_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [PRIO_W-1:0] prio_q,
   output logic [TGT_W-1:0]  tgt_q,
   output logic              en_q,
   output logic              pol_q,
   output logic              sw_q
);
   chan_strobe_t stb;
   logic         tgt_ok;

   always_comb begin
      stb         = '0;
      stb.sw_set  = wr & wdata[BIT_SW_SET];
      stb.sw_clr  = wr & wdata[BIT_SW_CLR];
      stb.we_prio = wr & wdata[BIT_WE_PRIO];
      stb.we_tgt  = wr & wdata[BIT_WE_TGT];
      stb.we_en   = wr & wdata[BIT_WE_EN];
      stb.we_pol  = wr & wdata[BIT_WE_POL];
   end

   // target may change only while the channel is disabled
   assign tgt_ok = stb.we_tgt & ~en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
         tgt_q  <= '0;
         en_q   <= 1'b0;
         pol_q  <= 1'b0;
         sw_q   <= 1'b0;
      end else begin
         if (stb.we_prio) prio_q <= wdata[LSB_PRIO +: PRIO_W];
         if (tgt_ok)      tgt_q  <= wdata[LSB_TGT +: TGT_W];
         if (stb.we_en)   en_q   <= wdata[BIT_EN];
         if (stb.we_pol)  pol_q  <= wdata[BIT_POL];
         if (stb.sw_clr)      sw_q <= 1'b0;
         else if (stb.sw_set) sw_q <= 1'b1;
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && wdata[BIT_WE_PRIO]) |=> $stable(prio_q)); // R6
   AST_TGT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q || !(wr && wdata[BIT_WE_TGT])) |=> $stable(tgt_q)); // R7
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && wdata[BIT_WE_EN]) |=> $stable(en_q)); // R8
   AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && wdata[BIT_WE_POL]) |=> $stable(pol_q)); // R9
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[BIT_SW_CLR]) |=> !sw_q); // R5
   AST_NO_WR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(prio_q) && $stable(tgt_q) && $stable(en_q)
               && $stable(pol_q) && $stable(sw_q))); // R12
endmodule

// File: rtl/irq_chan_status.sv
module irq_chan_status #(
   parameter int unsigned PRIO_W      = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raw_irq,
   input  logic              pol,
   input  logic              sw,
   input  logic              en,
   input  logic [PRIO_W-1:0] prio,
   output logic              pend,
   output logic              req
);
   logic raw_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign raw_s = raw_irq;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-1:0] , raw_irq} >> 0;
         end
         assign raw_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign pend = (raw_s ^ pol) | sw;
   assign req  = pend & en & (|prio);

   AST_SW_FORCES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      sw |-> pend); // R3
   AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (en && prio != '0)); // R11
endmodule

// File: rtl/irq_chan_rdmux.sv
module irq_chan_rdmux
   import irq_chan_pkg::*;
#(
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned TGT_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRIO_W-1:0] prio,
   input  logic [TGT_W-1:0]  tgt,
   input  logic              en,
   input  logic              pol,
   input  logic              pend,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata                       = '0;
      rdata[LSB_PRIO +: PRIO_W]   = prio;
      rdata[LSB_TGT +: TGT_W]     = tgt;
      rdata[BIT_EN]               = en;
      rdata[BIT_POL]              = pol;
      rdata[BIT_PEND]             = pend;
   end

   AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[30:18] == '0); // R10
endmodule

// File: rtl/irq_chan_reg.sv
module irq_chan_reg
   import irq_chan_pkg::*;
#(
   parameter int unsigned PRIO_W      = 4,
   parameter int unsigned TGT_W       = 1,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              raw_irq,
   output logic              pending,
   output logic              req,
   output logic [PRIO_W-1:0] req_prio,
   output logic [TGT_W-1:0]  req_tgt
);
   localparam int unsigned PRIO_TOP = LSB_PRIO + PRIO_W;
   localparam int unsigned TGT_TOP  = LSB_TGT + TGT_W;

   generate
      if (PRIO_W == 0 || PRIO_TOP > LSB_TGT) begin : g_bad_prio
         $error("irq_chan_reg: PRIO_W must be 1..%0d", LSB_TGT);
      end
      if (TGT_W == 0 || TGT_TOP > BIT_EN) begin : g_bad_tgt
         $error("irq_chan_reg: TGT_W must be 1..%0d", BIT_EN - LSB_TGT);
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("irq_chan_reg: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic              wr;
   logic [PRIO_W-1:0] prio_q;
   logic [TGT_W-1:0]  tgt_q;
   logic              en_q;
   logic              pol_q;
   logic              sw_q;

   assign wr = sel & wr_en;

   irq_chan_fields #(.PRIO_W(PRIO_W), .TGT_W(TGT_W)) u_fields (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr),
      .wdata  (wdata),
      .prio_q (prio_q),
      .tgt_q  (tgt_q),
      .en_q   (en_q),
      .pol_q  (pol_q),
      .sw_q   (sw_q)
   );

   irq_chan_status #(.PRIO_W(PRIO_W), .SYNC_STAGES(SYNC_STAGES)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_irq (raw_irq),
      .pol     (pol_q),
      .sw      (sw_q),
      .en      (en_q),
      .prio    (prio_q),
      .pend    (pending),
      .req     (req)
   );

   irq_chan_rdmux #(.PRIO_W(PRIO_W), .TGT_W(TGT_W)) u_rdmux (
      .clk   (clk),
      .rst_n (rst_n),
      .prio  (prio_q),
      .tgt   (tgt_q),
      .en    (en_q),
      .pol   (pol_q),
      .pend  (pending),
      .rdata (rdata)
   );

   assign req_prio = prio_q;
   assign req_tgt  = tgt_q;

   AST_RD_PEND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[BIT_PEND] == pending); // R2
   AST_SWSET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[BIT_SW_SET] && !wdata[BIT_SW_CLR]) |=> pending); // R4
endmodule

// File: tb/irq_chan_reg_tb_top.sv
`timescale 1ns/1ps
module irq_chan_reg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        raw_irq = 1'b0;
   logic        pending;
   logic        req;
   logic [3:0]  req_prio;
   logic [0:0]  req_tgt;

   always #2.5 clk = ~clk;

   irq_chan_reg dut_i (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .raw_irq(raw_irq), .pending(pending), .req(req),
      .req_prio(req_prio), .req_tgt(req_tgt)
   );

   typedef struct {
      string       tag;
      logic [31:0] rd;
      logic        pend;
      logic        rq;
      logic [3:0]  prio;
      logic        tgt;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 0;

   // requirement model state
   logic [3:0] m_prio = '0;
   logic       m_tgt = 0, m_en = 0, m_pol = 0, m_sw = 0, m_raw = 0;

   function automatic logic m_pend();
      return (m_raw ^ m_pol) | m_sw;
   endfunction

   // driver side: push the expectation built from the model
   task automatic expect_now(input string tag);
      exp_t e;
      e.tag  = tag;
      e.pend = m_pend();
      e.rq   = e.pend & m_en & (m_prio != 0);
      e.rd   = '0;
      e.rd[3:0] = m_prio;
      e.rd[8]   = m_tgt;
      e.rd[16]  = m_en;
      e.rd[17]  = m_pol;
      e.rd[31]  = e.pend;
      e.prio = m_prio;
      e.tgt  = m_tgt;
      q.push_back(e);
   endtask

   task automatic bus_write(input logic s, input logic w, input logic [31:0] d);
      @(posedge clk); #1;
      sel = s; wr_en = w; wdata = d;
      @(posedge clk); #1;
      sel = 0; wr_en = 0; wdata = '0;
      if (s && w) begin
         if (d[28]) m_prio = d[3:0];
         if (d[27] && !m_en) m_tgt = d[8];
         if (d[26]) m_en = d[16];
         if (d[25]) m_pol = d[17];
         if (d[29]) m_sw = 0;
         else if (d[30]) m_sw = 1;
      end
   endtask

   task automatic set_raw(input logic v);
      @(posedge clk); #1;
      raw_irq = v; m_raw = v;
   endtask

   // monitor: compare at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (rdata !== e.rd || pending !== e.pend || req !== e.rq ||
                req_prio !== e.prio || req_tgt[0] !== e.tgt) begin
               n_errors++;
               $display("FAIL %s: rdata=%h pend=%b req=%b prio=%h tgt=%b expected rdata=%h pend=%b req=%b prio=%h tgt=%b",
                        e.tag, rdata, pending, req, req_prio, req_tgt, e.rd, e.pend, e.rq, e.prio, e.tgt);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      expect_now("R1 reset state");
      set_raw(1);
      expect_now("R2 R3 raw high pends, R11 no req while disabled");
      bus_write(1, 1, 32'h0000_0005);
      expect_now("R6 prio held without write-enable");
      bus_write(1, 1, 32'h1000_0005);
      expect_now("R6 prio updated");
      bus_write(1, 1, 32'h0401_0000);
      expect_now("R8 enable set, R11 req asserted");
      bus_write(1, 1, 32'h0800_0100);
      expect_now("R7 target write refused while enabled");
      bus_write(1, 1, 32'h0400_0000);
      expect_now("R8 enable cleared");
      bus_write(1, 1, 32'h0800_0100);
      expect_now("R7 target updated while disabled");
      bus_write(1, 1, 32'h0202_0000);
      expect_now("R9 polarity set, R3 raw high no longer pends");
      set_raw(0);
      expect_now("R3 active-low raw low pends");
      bus_write(1, 1, 32'h0200_0000);
      expect_now("R9 polarity cleared, nothing pending");
      bus_write(1, 1, 32'h4000_0000);
      expect_now("R4 software set pends, R10 strobe reads 0");
      bus_write(1, 1, 32'h0000_0000);
      expect_now("R4 zero write leaves flag");
      bus_write(1, 1, 32'h2000_0000);
      expect_now("R5 software clear");
      bus_write(1, 1, 32'h4000_0000);
      bus_write(1, 1, 32'h6000_0000);
      expect_now("R5 clear wins over set");
      bus_write(0, 1, 32'h5E03_010F);
      expect_now("R12 unselected write ignored");
      bus_write(1, 0, 32'h5E03_010F);
      expect_now("R12 read cycle changes nothing");
      bus_write(1, 1, 32'hFFFF_FFFF);
      expect_now("R10 all-ones write, R7 target with enable in same write");
      set_raw(0);
      bus_write(1, 1, 32'h4000_0000);
      expect_now("R11 req with prio nonzero via software flag");
      bus_write(1, 1, 32'h1000_0000);
      expect_now("R11 zero priority blocks req");
      bus_write(1, 1, 32'h0800_0000);
      expect_now("R7 target write refused after all-ones enable");
      @(negedge clk); @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule